// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN bit-level receiver and decides which receive mailbox, if any, takes each decoded frame. A bank of mailboxes holds, for each entry, a pair of identifier words, a pair of mask words, a length word and four payload words. When a frame arrives, its identifier is compared against every enabled receive mailbox of the same identifier format. The lowest-numbered mailbox that matches stores the frame and raises its receive flag. A frame that no mailbox accepts is discarded without changing any state.

Software programs the bank through a simple write port and inspects it through a combinational read port. Software clears receive flags by writing ones to them. A frame that lands in a mailbox whose flag is still set marks that mailbox as overrun, and the overrun mark stays until software clears it. The receive flags are also brought out as a vector so that they can drive an interrupt.

Top module: `canf_filter`

## Requirements
- R1: After reset, every mailbox word and every enable, direction, receive-flag and overrun bit reads zero, and `rxFlag` is zero.
- R2: With `wrAddr[9]`=1 the address selects mailbox `wrAddr[8:4]` and word `wrAddr[3:0]`: 0 identifier low, 1 identifier high, 2 mask low, 3 mask high, 4 length, 5..8 payload. Words above 8 are ignored. The mask-high word keeps only bits 12:0. With `wrAddr[9]`=0, `wrAddr[2:1]` selects enable (0), direction (1), receive flags (2) or overrun (3), and `wrAddr[0]` selects mailboxes 0-15 (0) or 16-31 (1). Enable and direction are written directly, and the read port uses the same map.
- R3: Identifier-high bit 13 is the format bit. A mailbox with that bit clear accepts only standard frames, and compares the frame's 11-bit identifier with identifier-high bits 12:2 while ignoring its identifier-low word. A mailbox with the bit set accepts only extended frames.
- R4: An extended mailbox compares all 29 identifier bits. The frame's bits 28:16 are compared with identifier-high bits 12:0, and its bits 15:0 with the identifier-low word.
- R5: When identifier-high bit 15 is set, a mask bit of one makes the identifier bit in the same position a don't-care. The mask-high bits line up with identifier-high bits 12:0, and the mask-low bits with the identifier-low word. When bit 15 is clear, every compared bit must be equal.
- R6: Only a mailbox whose enable bit is 1 and whose direction bit is 1 (receive) can take a frame.
- R7: When several mailboxes match, the lowest-numbered one takes the frame. A frame that no mailbox matches changes no state.
- R8: One cycle after `frmValid`, the chosen mailbox holds the frame.
  - Identifier: for an extended frame, bits 28:16 are in identifier-high bits 12:0 and bits 15:0 are in identifier-low. For a standard frame, the identifier is in identifier-high bits 12:2 and identifier-low is zero.
  - Flag bits: identifier-high bit 14 is the frame's remote-request bit, and bits 15 and 13 keep their earlier values.
  - Length: the length word holds the length code in bits 3:0.
  - Payload: payload word k holds byte 7-2k in bits 7:0 and byte 6-2k in bits 15:8.
  - Receive flag: the mailbox's receive flag is 1.
- R9: Writing a one to a receive-flag bit clears it. A frame stored in the same cycle wins, so the flag stays set.
- R10: A frame stored in a mailbox whose receive flag was already set sets that mailbox's overrun bit. The overrun bit stays set until software writes a one to it, and a new overrun in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmValid | input | 1 | One-cycle strobe: a decoded frame is present |
| frmIde | input | 1 | Frame uses the 29-bit identifier format |
| frmRtr | input | 1 | Frame is a remote request |
| frmId | input | 29 | Identifier (standard frames use bits 10:0) |
| frmDlc | input | 4 | Length code |
| frmData | input | 64 | Payload, byte k in bits 8k+7:8k |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 10 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 10 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| rxFlag | output | 32 | Receive flag of each mailbox |

## Verification
Some internal faults show up on `rxFlag` in the cycle after the frame. Examples are a wrong match decision, a wrong priority pick or a misplaced identifier comparison. Such a fault sets the flag of the wrong mailbox, or of no mailbox. A fault in how the frame is stored is seen only when the affected word is read back, and that word reads wrong from the cycle after the store. Packing faults of this kind include a swapped payload byte, a truncated length code, a lost flag bit and identifier bits in the wrong place. Overrun and flag-clear faults show up on the next read of the global registers and on `rxFlag`. The reference model checks both of these every clock, so any divergence is reported within one cycle of the edge that causes it.

// File: rtl/canf_pkg.sv
`timescale 1ns/1ps
package canf_pkg;
  localparam int MBX_MAX  = 32;
  localparam int IDX_W    = $clog2(MBX_MAX);
  localparam int WORD_W   = 16;
  localparam int WPM      = 9;
  localparam int SEL_W    = 4;
  localparam int ADDR_W   = 1 + IDX_W + SEL_W;
  localparam int HI_ID_W  = 13;
  localparam int BIT_AME  = 15;
  localparam int BIT_RTR  = 14;
  localparam int BIT_IDE  = 13;

  typedef enum logic [SEL_W-1:0] {
    W_ID_LO  = 4'd0,
    W_ID_HI  = 4'd1,
    W_MSK_LO = 4'd2,
    W_MSK_HI = 4'd3,
    W_LEN    = 4'd4,
    W_DAT0   = 4'd5
  } word_e;

  typedef enum logic [1:0] {
    G_EN   = 2'd0,
    G_DIR  = 2'd1,
    G_FLAG = 2'd2,
    G_OVR  = 2'd3
  } glob_e;

  typedef struct packed {
    logic                store;
    logic [IDX_W-1:0]    idx;
    logic [HI_ID_W-1:0]  idHi;
    logic [WORD_W-1:0]   idLo;
  } strobe_t;
endpackage

// File: rtl/canf_match.sv
`timescale 1ns/1ps
module canf_match
  import canf_pkg::*;
#(
  parameter int NUM_MBX = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frmValid,
  input  logic                         frmIde,
  input  logic [28:0]                  frmId,
  input  logic [NUM_MBX-1:0]           mbxEn,
  input  logic [NUM_MBX-1:0]           mbxDir,
  input  logic [NUM_MBX-1:0][WORD_W-1:0] idLoV,
  input  logic [NUM_MBX-1:0][WORD_W-1:0] idHiV,
  input  logic [NUM_MBX-1:0][WORD_W-1:0] mskLoV,
  input  logic [NUM_MBX-1:0][WORD_W-1:0] mskHiV,
  output strobe_t                      st
);
  logic [HI_ID_W-1:0] fHi;
  logic [WORD_W-1:0]  fLo;
  logic [NUM_MBX-1:0] hit;

  assign fHi = frmIde ? frmId[28:16] : {frmId[10:0], 2'b00};
  assign fLo = frmIde ? frmId[15:0]  : '0;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_cmp
    logic               useMask;
    logic [HI_ID_W-1:0] hiDiff;
    logic [WORD_W-1:0]  loDiff;
    logic               idOk;
    assign useMask = idHiV[i][BIT_AME];
    assign hiDiff  = (idHiV[i][HI_ID_W-1:0] ^ fHi) & ~(mskHiV[i][HI_ID_W-1:0] & {HI_ID_W{useMask}});
    assign loDiff  = (idLoV[i] ^ fLo) & ~(mskLoV[i] & {WORD_W{useMask}});
    assign idOk    = frmIde ? (hiDiff == '0 && loDiff == '0) : (hiDiff[12:2] == '0);
    assign hit[i]  = frmValid & mbxEn[i] & mbxDir[i] & (idHiV[i][BIT_IDE] == frmIde) & idOk;
  end

  always_comb begin
    st.store = |hit;
    st.idx   = '0;
    st.idHi  = fHi;
    st.idLo  = fLo;
    for (int i = NUM_MBX - 1; i >= 0; i--) begin
      if (hit[i]) st.idx = IDX_W'(i);
    end
  end

  // R6: the chosen mailbox is enabled and set to receive
  a_r6_target_is_rx: assert property (@(posedge clk) disable iff (!rstN)
    st.store |-> (mbxEn[st.idx] && mbxDir[st.idx]));

  // R7: nothing is stored without a frame
  a_r7_store_needs_frame: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |-> !st.store);
endmodule

// File: rtl/canf_bank.sv
`timescale 1ns/1ps
module canf_bank
  import canf_pkg::*;
#(
  parameter int NUM_MBX = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [WORD_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [WORD_W-1:0]              rdData,
  input  logic                           frmRtr,
  input  logic [3:0]                     frmDlc,
  input  logic [63:0]                    frmData,
  input  strobe_t                        st,
  output logic [NUM_MBX-1:0]             mbxEn,
  output logic [NUM_MBX-1:0]             mbxDir,
  output logic [NUM_MBX-1:0][WORD_W-1:0] idLoV,
  output logic [NUM_MBX-1:0][WORD_W-1:0] idHiV,
  output logic [NUM_MBX-1:0][WORD_W-1:0] mskLoV,
  output logic [NUM_MBX-1:0][WORD_W-1:0] mskHiV,
  output logic [NUM_MBX-1:0]             rxFlag
);
  localparam int GW = (NUM_MBX + WORD_W - 1) / WORD_W;
  localparam int FW = GW * WORD_W;
  localparam logic [FW-1:0] LIVE = {FW{1'b1}} >> (FW - NUM_MBX);
  localparam logic [ADDR_W-1:0] FLAG_LO_ADDR = ADDR_W'({G_FLAG, 1'b0});

  logic [WORD_W-1:0] mem [NUM_MBX][WPM];
  logic [FW-1:0] enR, dirR, flagR, ovrR;

  logic              wrMbx;
  logic [IDX_W-1:0]  wrIdx;
  logic [SEL_W-1:0]  wrSel;
  glob_e             wrKind;
  logic [FW-1:0]     laneVal, laneMsk, setVec, flagClr, ovrClr;
  logic              wrGlob;

  assign wrMbx   = wrAddr[ADDR_W-1];
  assign wrIdx   = wrAddr[SEL_W +: IDX_W];
  assign wrSel   = wrAddr[SEL_W-1:0];
  assign wrKind  = glob_e'(wrAddr[2:1]);
  assign wrGlob  = wrEn && !wrMbx;
  assign laneVal = (FW'(wrData) << (wrAddr[0] ? WORD_W : 0)) & LIVE;
  assign laneMsk = (FW'({WORD_W{1'b1}}) << (wrAddr[0] ? WORD_W : 0)) & LIVE;
  assign setVec  = st.store ? ((FW'(1) << st.idx) & LIVE) : '0;
  assign flagClr = (wrGlob && wrKind == G_FLAG) ? laneVal : '0;
  assign ovrClr  = (wrGlob && wrKind == G_OVR)  ? laneVal : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MBX; i++)
        for (int w = 0; w < WPM; w++) mem[i][w] <= '0;
      enR   <= '0;
      dirR  <= '0;
      flagR <= '0;
      ovrR  <= '0;
    end else begin
      if (wrEn && wrMbx && int'(wrIdx) < NUM_MBX && int'(wrSel) < WPM)
        mem[wrIdx][wrSel] <= (wrSel == W_MSK_HI) ? (wrData & 16'h1FFF) : wrData;
      if (wrGlob && wrKind == G_EN)  enR  <= (enR  & ~laneMsk) | laneVal;
      if (wrGlob && wrKind == G_DIR) dirR <= (dirR & ~laneMsk) | laneVal;
      if (st.store) begin
        mem[st.idx][W_ID_LO] <= st.idLo;
        mem[st.idx][W_ID_HI] <= {mem[st.idx][W_ID_HI][BIT_AME], frmRtr,
                                 mem[st.idx][W_ID_HI][BIT_IDE], st.idHi};
        mem[st.idx][W_LEN]   <= {12'b0, frmDlc};
        for (int k = 0; k < 4; k++)
          mem[st.idx][int'(W_DAT0) + k] <= {frmData[8*(6-2*k) +: 8], frmData[8*(7-2*k) +: 8]};
      end
      flagR <= (flagR & ~flagClr) | setVec;
      ovrR  <= (ovrR & ~ovrClr) | (setVec & flagR);
    end
  end

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_exp
    assign idLoV[i]  = mem[i][W_ID_LO];
    assign idHiV[i]  = mem[i][W_ID_HI];
    assign mskLoV[i] = mem[i][W_MSK_LO];
    assign mskHiV[i] = mem[i][W_MSK_HI];
  end

  assign mbxEn  = enR[NUM_MBX-1:0];
  assign mbxDir = dirR[NUM_MBX-1:0];
  assign rxFlag = flagR[NUM_MBX-1:0];

  logic [IDX_W-1:0] rdIdx;
  logic [SEL_W-1:0] rdSel;
  logic [FW-1:0]    rdVec;
  assign rdIdx = rdAddr[SEL_W +: IDX_W];
  assign rdSel = rdAddr[SEL_W-1:0];

  always_comb begin
    rdData = '0;
    case (glob_e'(rdAddr[2:1]))
      G_EN:    rdVec = enR;
      G_DIR:   rdVec = dirR;
      G_FLAG:  rdVec = flagR;
      default: rdVec = ovrR;
    endcase
    if (rdAddr[ADDR_W-1]) begin
      if (int'(rdIdx) < NUM_MBX && int'(rdSel) < WPM) rdData = mem[rdIdx][rdSel];
    end else begin
      rdData = WORD_W'(rdVec >> (rdAddr[0] ? WORD_W : 0));
    end
  end

  // R8: a stored frame raises its mailbox flag on the next cycle
  a_r8_flag_after_store: assert property (@(posedge clk) disable iff (!rstN)
    st.store |=> flagR[$past(st.idx)]);

  // R10: storing into a flagged mailbox marks it overrun
  a_r10_overrun_on_restore: assert property (@(posedge clk) disable iff (!rstN)
    (st.store && flagR[st.idx]) |=> ovrR[$past(st.idx)]);

  // R9: clearing mailbox 0's flag works unless a frame lands there
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == FLAG_LO_ADDR && wrData[0] && !(st.store && st.idx == '0)) |=> !flagR[0]);
endmodule

// File: rtl/canf_filter.sv
`timescale 1ns/1ps
module canf_filter
  import canf_pkg::*;
#(
  parameter int NUM_MBX = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frmValid,
  input  logic                 frmIde,
  input  logic                 frmRtr,
  input  logic [28:0]          frmId,
  input  logic [3:0]           frmDlc,
  input  logic [63:0]          frmData,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_MBX-1:0]   rxFlag
);
  strobe_t                        st;
  logic [NUM_MBX-1:0]             mbxEn, mbxDir;
  logic [NUM_MBX-1:0][WORD_W-1:0] idLoV, idHiV, mskLoV, mskHiV;

  canf_match #(.NUM_MBX(NUM_MBX)) u_match (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmIde(frmIde), .frmId(frmId),
    .mbxEn(mbxEn), .mbxDir(mbxDir), .idLoV(idLoV), .idHiV(idHiV),
    .mskLoV(mskLoV), .mskHiV(mskHiV), .st(st)
  );

  canf_bank #(.NUM_MBX(NUM_MBX)) u_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .frmRtr(frmRtr), .frmDlc(frmDlc),
    .frmData(frmData), .st(st), .mbxEn(mbxEn), .mbxDir(mbxDir),
    .idLoV(idLoV), .idHiV(idHiV), .mskLoV(mskLoV), .mskHiV(mskHiV),
    .rxFlag(rxFlag)
  );
endmodule

// File: tb/canf_filter_tb.sv
`timescale 1ns/1ps
module canf_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0, frmIde = 1'b0, frmRtr = 1'b0;
  logic [28:0] frmId = '0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [31:0] rxFlag;

  int nRun = 0, nFail = 0;
  bit over = 0;

  always #5 clk = ~clk;

  canf_filter u_dut (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmIde(frmIde), .frmRtr(frmRtr),
    .frmId(frmId), .frmDlc(frmDlc), .frmData(frmData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .rxFlag(rxFlag)
  );

  // reference model state
  logic [15:0] mR [32][9];
  logic [31:0] mEn, mDir, mFlag, mOvr;

  task automatic note(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(logic [9:0] a);
    logic [31:0] v;
    if (a[9]) return (a[3:0] < 9) ? mR[a[8:4]][a[3:0]] : 16'h0;
    case (a[2:1])
      2'd0: v = mEn;
      2'd1: v = mDir;
      2'd2: v = mFlag;
      default: v = mOvr;
    endcase
    return a[0] ? v[31:16] : v[15:0];
  endfunction

  task automatic modelStep();
    int tgt = -1;
    logic [15:0] oldHi;
    logic [31:0] clrF = 0, clrO = 0, val, oldFlag;
    if (frmValid) begin
      for (int i = 0; i < 32; i++) begin
        logic [15:0] hi = mR[i][1];
        bit ok = 0;
        if (tgt < 0 && mEn[i] && mDir[i] && hi[13] == frmIde) begin
          if (!frmIde) begin
            int mid = (hi >> 2) & 'h7FF;
            int mm  = hi[15] ? ((mR[i][3] >> 2) & 'h7FF) : 0;
            ok = (((mid ^ int'(frmId[10:0])) & ~mm) == 0);
          end else begin
            logic [28:0] mid = {hi[12:0], mR[i][0]};
            logic [28:0] mm  = hi[15] ? {mR[i][3][12:0], mR[i][2]} : 29'h0;
            ok = (((mid ^ frmId) & ~mm) == 0);
          end
          if (ok) tgt = i;
        end
      end
    end
    oldFlag = mFlag;
    if (tgt >= 0) oldHi = mR[tgt][1];
    if (wrEn) begin
      if (wrAddr[9]) begin
        if (wrAddr[3:0] < 9)
          mR[wrAddr[8:4]][wrAddr[3:0]] = (wrAddr[3:0] == 3) ? (wrData & 16'h1FFF) : wrData;
      end else begin
        val = wrAddr[0] ? {wrData, 16'h0} : {16'h0, wrData};
        case (wrAddr[2:1])
          2'd0: mEn  = (mEn  & ~(wrAddr[0] ? 32'hFFFF0000 : 32'h0000FFFF)) | val;
          2'd1: mDir = (mDir & ~(wrAddr[0] ? 32'hFFFF0000 : 32'h0000FFFF)) | val;
          2'd2: clrF = val;
          default: clrO = val;
        endcase
      end
    end
    mFlag = mFlag & ~clrF;
    mOvr  = mOvr & ~clrO;
    if (tgt >= 0) begin
      mR[tgt][0] = frmIde ? frmId[15:0] : 16'h0;
      mR[tgt][1] = (oldHi & 16'hA000) | (16'(frmRtr) << 14) |
                   (frmIde ? 16'(frmId[28:16]) : 16'({frmId[10:0], 2'b00}));
      mR[tgt][4] = 16'(frmDlc);
      for (int k = 0; k < 4; k++)
        mR[tgt][5+k] = {frmData[8*(6-2*k) +: 8], frmData[8*(7-2*k) +: 8]};
      if (oldFlag[tgt]) mOvr[tgt] = 1'b1;
      mFlag[tgt] = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) for (int w = 0; w < 9; w++) mR[i][w] = 16'h0;
      mEn = 0; mDir = 0; mFlag = 0; mOvr = 0;
    end else begin
      modelStep();
    end
    #2;
    note(rxFlag == mFlag, "R8 per-cycle rxFlag vs model", rxFlag, mFlag);
    note(rdData == modelRead(rdAddr), "R2 per-cycle rdData vs model", 32'(rdData), 32'(modelRead(rdAddr)));
  end

  function automatic logic [9:0] mA(int idx, int sel);
    return {1'b1, 5'(idx), 4'(sel)};
  endfunction
  function automatic logic [9:0] gA(int kind, int half);
    return {7'b0, 2'(kind), 1'(half)};
  endfunction

  task automatic wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic sendFrame(bit ide, bit rtr, logic [28:0] id, logic [3:0] dlc,
                           logic [63:0] dat, bit clr0);
    @(negedge clk);
    frmValid = 1; frmIde = ide; frmRtr = rtr; frmId = id; frmDlc = dlc; frmData = dat;
    if (clr0) begin wrEn = 1; wrAddr = gA(2, 0); wrData = 16'h0001; end
    @(negedge clk); frmValid = 0; wrEn = 0;
  endtask

  task automatic readChk(logic [9:0] a, logic [15:0] exp, string tag);
    @(negedge clk); rdAddr = a; #1;
    note(rdData == exp, tag, 32'(rdData), 32'(exp));
  endtask

  task automatic flagChk(logic [31:0] exp, string tag);
    @(negedge clk); #1;
    note(rxFlag == exp, tag, rxFlag, exp);
  endtask

  task automatic finishUp();
    over = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(10 * 100000);
    if (!over) begin
      nFail++;
      $display("FAIL watchdog R1 sequence not completed actual=timeout expected=done");
      finishUp();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    readChk(gA(0, 0), 16'h0000, "R1 enable after reset");
    readChk(gA(2, 1), 16'h0000, "R1 flags high after reset");
    readChk(mA(7, 1), 16'h0000, "R1 mailbox word after reset");
    flagChk(32'h0, "R1 rxFlag after reset");

    // configuration
    wr(gA(0, 0), 16'h003F);
    wr(gA(1, 0), 16'h005F);
    wr(mA(0, 1), 16'h048C);                 // std 0x123 exact
    wr(mA(1, 1), 16'h8480); wr(mA(1, 3), 16'h003C); wr(mA(1, 0), 16'h5A5A);
    wr(mA(2, 1), 16'h3ABC); wr(mA(2, 0), 16'hDEF0);
    wr(mA(3, 1), 16'hA000); wr(mA(3, 3), 16'hFFFF); wr(mA(3, 2), 16'hFFFF);
    wr(mA(5, 1), 16'h1554);
    wr(mA(6, 1), 16'h1554);
    wr(mA(4, 9), 16'hBEEF);
    readChk(gA(0, 0), 16'h003F, "R2 enable readback");
    readChk(gA(1, 0), 16'h005F, "R2 direction readback");
    readChk(mA(3, 3), 16'h1FFF, "R2 mask high keeps 13 bits");
    readChk(mA(4, 9), 16'h0000, "R2 word above 8 ignored");

    // F1: std 0x123, mailboxes 0 and 1 both match, 0 wins
    sendFrame(0, 0, 29'h123, 4'd8, 64'h8877665544332211, 0);
    flagChk(32'h1, "R7 lowest mailbox takes frame");
    readChk(mA(0, 1), 16'h048C, "R8 std identifier stored");
    readChk(mA(0, 4), 16'h0008, "R8 length code stored");
    readChk(mA(0, 5), 16'h7788, "R8 payload word0 packing");
    readChk(mA(0, 8), 16'h1122, "R8 payload word3 packing");

    // F2: std 0x12A remote, exact mailbox 0 misses, masked mailbox 1 hits
    sendFrame(0, 1, 29'h12A, 4'd1, 64'h00000000000000AB, 0);
    flagChk(32'h3, "R5 masked match and exact miss");
    readChk(mA(1, 1), 16'hC4A8, "R8 remote bit stored with kept flags");
    readChk(mA(1, 0), 16'h0000, "R3 std store zeroes low word");

    // F3: std 0x133 misses every mailbox
    sendFrame(0, 0, 29'h133, 4'd2, 64'h0, 0);
    flagChk(32'h3, "R7 unmatched frame dropped");
    readChk(mA(0, 4), 16'h0008, "R7 dropped frame leaves mailbox");

    // F4: extended exact, mailbox 2 beats accept-all mailbox 3
    sendFrame(1, 0, 29'h1ABCDEF0, 4'd3, 64'h0102030405060708, 0);
    flagChk(32'h7, "R4 extended exact match");
    readChk(mA(2, 4), 16'h0003, "R8 extended length");
    readChk(mA(2, 1), 16'h3ABC, "R8 extended high word");

    // F5: extended 0x123: std mailbox 0 must not take it
    sendFrame(1, 0, 29'h123, 4'd0, 64'h0, 0);
    flagChk(32'h0F, "R3 format bit separates std and ext");
    readChk(mA(3, 0), 16'h0123, "R4 extended low word stored");
    readChk(mA(3, 1), 16'hA000, "R5 accept-all keeps flags");

    // F6: std 0x555: mailbox 5 is transmit, mailbox 6 disabled
    sendFrame(0, 0, 29'h555, 4'd4, 64'h0, 0);
    flagChk(32'h0F, "R6 tx or disabled mailbox ignored");
    readChk(mA(6, 4), 16'h0000, "R6 disabled mailbox untouched");

    // F7: overrun on mailbox 0
    sendFrame(0, 0, 29'h123, 4'd2, 64'h0, 0);
    readChk(gA(3, 0), 16'h0001, "R10 overrun set");
    readChk(mA(0, 4), 16'h0002, "R10 newer frame replaces data");

    wr(gA(2, 0), 16'h0001);
    flagChk(32'h0E, "R9 write one clears flag");
    readChk(gA(2, 0), 16'h000E, "R9 flag register readback");
    wr(gA(3, 0), 16'h0001);
    readChk(gA(3, 0), 16'h0000, "R10 overrun cleared by write one");

    // store and clear in the same cycle
    sendFrame(0, 0, 29'h123, 4'd5, 64'h0, 1);
    flagChk(32'h0F, "R9 store wins over clear");
    readChk(gA(3, 0), 16'h0000, "R10 no overrun from clear flag");
    sendFrame(0, 0, 29'h123, 4'd6, 64'h0, 1);
    readChk(gA(3, 0), 16'h0001, "R10 overrun with same-cycle clear");
    flagChk(32'h0F, "R9 flag still set after combo");

    repeat (3) @(negedge clk);
    finishUp();
  end
endmodule